// File: doc/BRIEF.md
# AUX Channel Request Formatter

This block sits between a requester and a DisplayPort AUX channel engine. It takes one command descriptor at a time and checks it. The descriptor carries a 4-bit request code, a 20-bit address, a byte count and up to sixteen payload bytes. The block then packs the four-byte request header and streams the header, followed by any write payload, to the channel engine one byte per cycle.

After the last byte has been sent, the block accepts the reply from the engine. The reply is a status byte followed by any read data. The block decodes the status into an error class and a reply code. It keeps read data only up to the requested size, and hands back one response holding the code, the class, the byte count and the data.

Requests that are too long, or whose type is not a read or write, are turned into a response at once without sending anything. The block takes a new request only after the previous response has been consumed.

Top module: `aux_req_fmt`

## Requirements
- R1: A request with a count above 16 is never sent: no byte appears on the transmit port, and the response carries error class 4 with count 0 and reply code 0. This check has priority over the type check of R9.
- R2: Header byte 0 is address bits 7:0. Byte 1 is address bits 15:8. Byte 2 holds the request code in bits 7:4 and address bits 19:16 in bits 3:0.
- R3: Bits 3:0 of header byte 3 are the count minus one, or 0 when the count is 0.
- R4: Bits 7:4 of header byte 3 are 3 when the count is 0. Otherwise they are the low four bits of the transmit size, which is 4 + count for writes and 4 for reads. A 16-byte write therefore shows 4, and a 12-byte write shows 0.
- R5: A write sends the 4 header bytes followed by the payload, byte 0 of the payload first. A read sends only the header. tx_last marks the final byte.
- R6: A status byte of exactly 0x01 gives error class 1 (timeout), 0x02 gives class 2 (flags not zero) and 0x03 gives class 3 (generic error). Each of these responses carries count 0, reply code 0 and all-zero data.
- R7: On success, a read reports the number of data bytes received, capped at the requested count. Surplus bytes are dropped. A write reports its own count and ignores any returned data.
- R8: On success the reply code is bits 7:4 of the status byte and the error class is 0.
- R9: Bit 2 of the request code is masked off before the type check. After masking, codes 0 (I2C write), 1 (I2C read), 8 (native write) and 9 (native read) are valid, and any other code gives error class 5 with nothing sent. Bit 0 clear means write.
- R10: req_ready falls after a request is accepted and rises only after the response has been taken. A stalled transmit byte, or a stalled response, holds its value until it is taken.
- R11: After reset, req_ready is 1 and tx_valid, rx_ready and rsp_valid are 0, including when reset arrives in the middle of a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Descriptor offered |
| req_ready | output | 1 | Block idle, descriptor taken on this cycle |
| req_cmd | input | 4 | Request code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W (6) | Byte count |
| req_data | input | MAX_BYTES*8 (128) | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_ready | input | 1 | Engine takes the byte |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the request |
| rx_valid | input | 1 | Reply byte valid |
| rx_ready | output | 1 | Block takes the reply byte |
| rx_byte | input | 8 | Reply byte, status first |
| rx_last | input | 1 | Final reply byte |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_code | output | 4 | Reply code |
| rsp_err | output | 3 | Error class |
| rsp_count | output | CNT_W (5) | Result byte count |
| rsp_data | output | MAX_BYTES*8 (128) | Read data, byte i at bits 8i+7:8i |

## Verification
The bench builds the block with its default MAX_BYTES of 16. This size reaches both ends of the size nibble: the 16-byte write, whose transmit size of 20 wraps to 4, and the 12-byte write, whose size of 16 wraps to 0. The size is also the threshold, so a count of 17 or 20 falls just past it for the rejection path. The 16-byte buffer lets the bench return more reply bytes than were asked for and see them clamped.

// File: rtl/aux_req_pkg.sv
// Shared types for the AUX request formatter.
package aux_req_pkg;

    // Error class reported with every response.
    typedef enum logic [2:0] {
        ERR_NONE     = 3'd0,
        ERR_TIMEOUT  = 3'd1,
        ERR_FLAGS    = 3'd2,
        ERR_FAIL     = 3'd3,
        ERR_TOO_BIG  = 3'd4,
        ERR_BAD_TYPE = 3'd5
    } aux_err_e;

    // Sequencer states of the top module.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_RECV = 2'd2,
        ST_RESP = 2'd3
    } aux_state_e;

    // Map a reply status byte to an error class.
    function automatic aux_err_e status_class(input logic [7:0] st);
        case (st)
            8'h01:   return ERR_TIMEOUT;
            8'h02:   return ERR_FLAGS;
            8'h03:   return ERR_FAIL;
            default: return ERR_NONE;
        endcase
    endfunction

endpackage

// File: rtl/aux_hdr_pack.sv
// Combinational header builder and request checker.
// Assumes MAX_BYTES <= 16 so the count minus one fits the 4-bit field.
module aux_hdr_pack
    import aux_req_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int LEN_W     = $clog2(MAX_BYTES) + 2,
    parameter int IDX_W     = $clog2(MAX_BYTES + 5)
) (
    input  logic [3:0]       cmd,
    input  logic [19:0]      addr,
    input  logic [LEN_W-1:0] len,
    output logic [31:0]      hdr,
    output logic             is_write,
    output logic [IDX_W-1:0] total,
    output aux_err_e         rej
);
    logic [3:0] base_cmd;
    logic [3:0] lo_nib;
    logic [3:0] hi_nib;
    logic [LEN_W-1:0] len_m1;

    // Classify the request and size the transmit stream.
    always_comb begin
        base_cmd = cmd & 4'b1011;
        is_write = ~cmd[0];
        total    = is_write ? (IDX_W'(len) + IDX_W'(4)) : IDX_W'(4);
        if (len > LEN_W'(MAX_BYTES))
            rej = ERR_TOO_BIG;
        else if (!(base_cmd == 4'd0 || base_cmd == 4'd1 ||
                   base_cmd == 4'd8 || base_cmd == 4'd9))
            rej = ERR_BAD_TYPE;
        else
            rej = ERR_NONE;
    end

    // Assemble the four header bytes, byte 0 in the low bits.
    always_comb begin
        len_m1 = len - LEN_W'(1);
        lo_nib = (len == '0) ? 4'd0 : len_m1[3:0];
        hi_nib = (len == '0) ? 4'd3 : 4'(total);
        hdr    = {hi_nib, lo_nib, cmd, addr[19:16], addr[15:8], addr[7:0]};
    end

endmodule

// File: rtl/aux_tx_ser.sv
// Byte serializer: header bytes first, then the write payload.
// Assumes total >= 4 and total <= MAX_BYTES + 4 while sending.
module aux_tx_ser #(
    parameter int MAX_BYTES = 16,
    parameter int IDX_W     = $clog2(MAX_BYTES + 5)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   active,
    input  logic                   advance,
    input  logic [31:0]            hdr,
    input  logic [MAX_BYTES*8-1:0] payload,
    input  logic [IDX_W-1:0]       total,
    output logic [7:0]             byte_out,
    output logic                   last
);
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] pidx;

    // Byte position counter, cleared on each new request.
    always_ff @(posedge clk) begin
        if (!rst_n)       idx <= '0;
        else if (start)   idx <= '0;
        else if (advance) idx <= idx + IDX_W'(1);
    end

    // Select the current header or payload byte.
    always_comb begin
        pidx = idx - IDX_W'(4);
        if (idx < IDX_W'(4)) byte_out = hdr[{idx[1:0], 3'b000} +: 8];
        else                 byte_out = payload[8*pidx +: 8];
        last = (idx == total - IDX_W'(1));
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> idx < total) else $error("index past end"); // R5

endmodule

// File: rtl/aux_rx_dec.sv
// Reply collector: keeps the status byte, stores read data up to a limit.
// Assumes the first byte after start is the status byte.
module aux_rx_dec #(
    parameter int MAX_BYTES = 16,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic                   fire,
    input  logic                   is_read,
    input  logic [CNT_W-1:0]       lim,
    input  logic [7:0]             rx_byte,
    output logic [7:0]             status,
    output logic [CNT_W-1:0]       cnt,
    output logic [MAX_BYTES*8-1:0] data
);
    logic got_status;
    logic store;

    assign store = fire && got_status && is_read && (cnt < lim);

    // Capture the status byte once per transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            got_status <= 1'b0;
            status     <= '0;
        end else if (start) begin
            got_status <= 1'b0;
            status     <= '0;
        end else if (fire && !got_status) begin
            got_status <= 1'b1;
            status     <= rx_byte;
        end
    end

    // Count stored data bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt <= '0;
        else if (start) cnt <= '0;
        else if (store) cnt <= cnt + CNT_W'(1);
    end

    // One register per data byte, written at its position.
    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)                            data[8*g +: 8] <= '0;
            else if (start)                        data[8*g +: 8] <= '0;
            else if (store && cnt == CNT_W'(g))    data[8*g +: 8] <= rx_byte;
        end
    end

    AST_RX_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= lim || start) else $error("read count past limit"); // R7

endmodule

// File: rtl/aux_req_fmt.sv
// AUX request formatter top: accepts a descriptor, streams the request,
// collects the reply and presents one response. One transfer at a time.
module aux_req_fmt
    import aux_req_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    parameter int LEN_W     = $clog2(MAX_BYTES) + 2,
    parameter int CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [3:0]             req_cmd,
    input  logic [19:0]            req_addr,
    input  logic [LEN_W-1:0]       req_len,
    input  logic [MAX_BYTES*8-1:0] req_data,
    output logic                   tx_valid,
    input  logic                   tx_ready,
    output logic [7:0]             tx_byte,
    output logic                   tx_last,
    input  logic                   rx_valid,
    output logic                   rx_ready,
    input  logic [7:0]             rx_byte,
    input  logic                   rx_last,
    output logic                   rsp_valid,
    input  logic                   rsp_ready,
    output logic [3:0]             rsp_code,
    output logic [2:0]             rsp_err,
    output logic [CNT_W-1:0]       rsp_count,
    output logic [MAX_BYTES*8-1:0] rsp_data
);
    localparam int IDX_W = $clog2(MAX_BYTES + 5);

    aux_state_e             state;
    logic [3:0]             c_cmd;
    logic [19:0]            c_addr;
    logic [LEN_W-1:0]       c_len;
    logic [MAX_BYTES*8-1:0] c_data;
    aux_err_e               c_rej;
    logic [31:0]            hdr;
    logic                   is_write;
    logic [IDX_W-1:0]       total;
    aux_err_e               rej_now;
    logic                   req_fire, tx_fire, rx_fire, rsp_fire;
    logic [7:0]             status;
    logic [CNT_W-1:0]       rx_cnt;
    logic [MAX_BYTES*8-1:0] rx_data;
    aux_err_e               fin_err;

    assign req_ready = (state == ST_IDLE);
    assign tx_valid  = (state == ST_SEND);
    assign rx_ready  = (state == ST_RECV);
    assign rsp_valid = (state == ST_RESP);
    assign req_fire  = req_valid && req_ready;
    assign tx_fire   = tx_valid && tx_ready;
    assign rx_fire   = rx_valid && rx_ready;
    assign rsp_fire  = rsp_valid && rsp_ready;

    // Check the incoming descriptor before it is captured.
    aux_hdr_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_chk (
        .cmd(req_cmd), .addr(req_addr), .len(req_len),
        .hdr(), .is_write(), .total(), .rej(rej_now)
    );

    // Build the header from the captured descriptor.
    aux_hdr_pack #(.MAX_BYTES(MAX_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_hdr (
        .cmd(c_cmd), .addr(c_addr), .len(c_len),
        .hdr(hdr), .is_write(is_write), .total(total), .rej()
    );

    aux_tx_ser #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .start(req_fire), .active(tx_valid),
        .advance(tx_fire), .hdr(hdr), .payload(c_data), .total(total),
        .byte_out(tx_byte), .last(tx_last)
    );

    aux_rx_dec #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .start(req_fire), .fire(rx_fire),
        .is_read(~is_write), .lim(CNT_W'(c_len)), .rx_byte(rx_byte),
        .status(status), .cnt(rx_cnt), .data(rx_data)
    );

    // Capture the descriptor on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_cmd  <= '0;
            c_addr <= '0;
            c_len  <= '0;
            c_data <= '0;
            c_rej  <= ERR_NONE;
        end else if (req_fire) begin
            c_cmd  <= req_cmd;
            c_addr <= req_addr;
            c_len  <= req_len;
            c_data <= req_data;
            c_rej  <= rej_now;
        end
    end

    // Transfer sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else begin
            case (state)
                ST_IDLE: if (req_fire)
                             state <= (rej_now != ERR_NONE) ? ST_RESP : ST_SEND;
                ST_SEND: if (tx_fire && tx_last) state <= ST_RECV;
                ST_RECV: if (rx_fire && rx_last) state <= ST_RESP;
                ST_RESP: if (rsp_fire) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Form the response from the rejection or the decoded status.
    always_comb begin
        fin_err = (c_rej != ERR_NONE) ? c_rej : status_class(status);
        rsp_err = fin_err;
        if (fin_err != ERR_NONE) begin
            rsp_code  = '0;
            rsp_count = '0;
            rsp_data  = '0;
        end else begin
            rsp_code  = status[7:4];
            rsp_count = is_write ? CNT_W'(c_len) : rx_cnt;
            rsp_data  = rx_data;
        end
    end

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte) && $stable(tx_last)))
        else $error("tx byte changed while stalled"); // R10

    AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_err) && $stable(rsp_count)))
        else $error("response changed while stalled"); // R10

    AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fire && rej_now != ERR_NONE) |=> (!tx_valid && rsp_valid))
        else $error("rejected request was sent"); // R1

    AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err != 3'd0) |-> (rsp_count == '0 && rsp_code == 4'd0))
        else $error("error response carries data"); // R6

    AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_count <= CNT_W'(c_len))
        else $error("count above request"); // R7

endmodule

// File: tb/tb_aux_req_fmt.sv
module tb_aux_req_fmt;
    localparam int MB    = 16;
    localparam int LEN_W = $clog2(MB) + 2;
    localparam int CNT_W = $clog2(MB + 1);

    logic clk = 0;
    logic rst_n = 0;
    logic req_valid = 0, req_ready;
    logic [3:0] req_cmd = 0;
    logic [19:0] req_addr = 0;
    logic [LEN_W-1:0] req_len = 0;
    logic [MB*8-1:0] req_data = 0;
    logic tx_valid, tx_ready = 0, tx_last;
    logic [7:0] tx_byte;
    logic rx_valid = 0, rx_ready, rx_last = 0;
    logic [7:0] rx_byte = 0;
    logic rsp_valid, rsp_ready = 0;
    logic [3:0] rsp_code;
    logic [2:0] rsp_err;
    logic [CNT_W-1:0] rsp_count;
    logic [MB*8-1:0] rsp_data;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;

    aux_req_fmt dut (.*);

    typedef struct packed {
        logic [3:0] cmd; logic [19:0] addr; logic [5:0] len; logic [7:0] st;
        logic [4:0] nrx; logic [2:0] err; logic [3:0] code; logic [4:0] cnt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{4'h8, 20'h12345, 6'd3,  8'h00, 5'd0, 3'd0, 4'd0, 5'd3},
        '{4'h9, 20'hABCDE, 6'd4,  8'h20, 5'd6, 3'd0, 4'd2, 5'd4},
        '{4'h5, 20'h00050, 6'd0,  8'h00, 5'd0, 3'd0, 4'd0, 5'd0},
        '{4'h0, 20'hFFFFF, 6'd16, 8'h10, 5'd0, 3'd0, 4'd1, 5'd16},
        '{4'h8, 20'h0A5A5, 6'd12, 8'h00, 5'd1, 3'd0, 4'd0, 5'd12},
        '{4'h1, 20'h00100, 6'd8,  8'h01, 5'd3, 3'd1, 4'd0, 5'd0},
        '{4'h9, 20'h00200, 6'd2,  8'h02, 5'd2, 3'd2, 4'd0, 5'd0},
        '{4'h8, 20'h00300, 6'd1,  8'h03, 5'd0, 3'd3, 4'd0, 5'd0},
        '{4'h2, 20'h00400, 6'd2,  8'h00, 5'd0, 3'd5, 4'd0, 5'd0},
        '{4'h9, 20'h00500, 6'd17, 8'h00, 5'd0, 3'd4, 4'd0, 5'd0},
        '{4'hC, 20'h00600, 6'd5,  8'h30, 5'd0, 3'd0, 4'd3, 5'd5},
        '{4'hD, 20'h00700, 6'd8,  8'h40, 5'd3, 3'd0, 4'd4, 5'd3},
        '{4'h2, 20'h00800, 6'd20, 8'h00, 5'd0, 3'd4, 4'd0, 5'd0}
    };

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Expected transmit byte i, from R2..R5.
    function automatic logic [7:0] exp_tx(input vec_t v, input int i);
        int tot;
        logic [3:0] lo, hi;
        tot = v.cmd[0] ? 4 : 4 + int'(v.len);
        lo  = (v.len == 0) ? 4'd0 : 4'(v.len - 1);
        hi  = (v.len == 0) ? 4'd3 : 4'(tot);
        case (i)
            0: return v.addr[7:0];
            1: return v.addr[15:8];
            2: return {v.cmd, v.addr[19:16]};
            3: return {hi, lo};
            default: return 8'hA0 + 8'(i - 4);
        endcase
    endfunction

    task automatic run_vec(input vec_t v, input int k);
        int tot, n, w;
        bit done, rej;
        logic [MB*8-1:0] exp_d;
        rej = (v.err == 3'd4 || v.err == 3'd5);
        tot = v.cmd[0] ? 4 : 4 + int'(v.len);
        for (int i = 0; i < MB; i++) req_data[8*i +: 8] = 8'hA0 + 8'(i);
        req_cmd = v.cmd; req_addr = v.addr; req_len = v.len; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R10 busy after accept", req_ready, 0);
        if (!rej) begin
            n = 0; done = 0;
            while (!done) begin
                tx_ready = (cyc % 3) != 2;
                if (tx_valid && tx_ready) begin
                    chk(tx_byte == exp_tx(v, n), (n < 3) ? "R2 header" : (n == 3) ? "R3/R4 size byte" : "R5 payload",
                        tx_byte, exp_tx(v, n));
                    if (tx_last) done = 1;
                    n++;
                end
                @(negedge clk);
            end
            tx_ready = 0;
            chk(n == tot, "R5 byte count", n, tot);
            for (int j = 0; j <= int'(v.nrx); j++) begin
                rx_valid = 1;
                rx_byte  = (j == 0) ? v.st : 8'h50 + 8'(j - 1);
                rx_last  = (j == int'(v.nrx));
                w = 0;
                while (!rx_ready && w < 50) begin @(negedge clk); w++; end
                @(negedge clk);
            end
            rx_valid = 0; rx_last = 0;
        end
        w = 0;
        while (!rsp_valid && w < 50) begin
            if (rej) chk(!tx_valid, "R1 R9 nothing sent", tx_valid, 0);
            @(negedge clk); w++;
        end
        if (rej) chk(!tx_valid, "R1 R9 nothing sent", tx_valid, 0);
        // Hold the response one cycle to see it stays put.
        @(negedge clk);
        exp_d = '0;
        if (v.err == 0 && v.cmd[0])
            for (int j = 0; j < int'(v.cnt); j++) exp_d[8*j +: 8] = 8'h50 + 8'(j);
        chk(rsp_valid, "R10 response held", rsp_valid, 1);
        chk(rsp_err == v.err, "R1 R6 R9 error class", rsp_err, v.err);
        chk(rsp_code == v.code, "R8 reply code", rsp_code, v.code);
        chk(rsp_count == v.cnt, "R7 count", rsp_count, v.cnt);
        chk(rsp_data == exp_d, "R6 R7 data", rsp_data[63:0], exp_d[63:0]);
        rsp_ready = 1;
        @(negedge clk);
        rsp_ready = 0;
        chk(req_ready && !rsp_valid, "R10 ready after response", req_ready, 1);
        if (k < 0) $display("unused");
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(req_ready && !tx_valid && !rx_ready && !rsp_valid, "R11 reset state",
            {req_ready, tx_valid, rx_ready, rsp_valid}, 4'b1000);
        @(negedge clk);
        for (int k = 0; k < NV; k++) run_vec(VECS[k], k);
        // Reset in the middle of a write.
        req_cmd = 4'h8; req_addr = 20'h00A00; req_len = 6'd4; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(tx_valid, "R5 write started", tx_valid, 1);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk(req_ready && !tx_valid && !rx_ready && !rsp_valid, "R11 reset mid-transfer",
            {req_ready, tx_valid, rx_ready, rsp_valid}, 4'b1000);
        @(negedge clk);
        run_vec(VECS[1], 99);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule